// File: doc/BRIEF.md
# TMDS Channel Sampling-Phase Aligner

This block sets the sampling phase of one data channel of a DVI receiver. A deserializer ahead of it delivers one 10-bit word per word-clock cycle. The block controls an adjustable input delay line through three single-cycle pulses: step up, step down, and load an absolute tap value. It then rates each tap setting by watching the control tokens that DVI blanking intervals carry.

A tap is good when enough long runs of control tokens arrive within a fixed observation window. A tap that sits near a bit transition corrupts the words, and the token runs break up. After a start request the block sweeps every tap from zero upward. It waits for the delay line to settle after each change, then measures. It keeps the widest unbroken stretch of good taps, which is the open eye, and steps back down to the middle of that stretch.

When it is done, the block reports either lock or failure, together with the eye width in taps. The eye must be at least a configurable minimum width for lock. An HDMI stream carries shorter token runs mixed with other data, so it fails this test and is reported as not locked. Software or a supervising state machine may pulse start again to retry.

Top module: `tmds_phase_aligner`

## Requirements
- R1: After reset, busy, locked and failed are 0, eye_size is 0, tap_value is 0, and no tap control pulse is active.
- R2: A start pulse while idle sets busy in the next cycle. In that same cycle it clears locked, failed and eye_size, and issues tap_load with tap_value 0. A start pulse while busy is ignored, and no second tap_load occurs.
- R3: Exactly four words count as control tokens: 1101010100, 0010101011, 0101010100 and 1010101011, written MSB first (bit 9 on the left). Every other word is a non-token.
- R4: After every tap change the block waits SETTLE cycles. It then observes WINDOW words. The tap is good when at least MIN_RUNS separate runs of at least MIN_RUN consecutive tokens occur in that window.
- R5: One sweep tests every tap from 0 to 2^TAP_W-1 in ascending order. It moves by exactly 2^TAP_W-1 tap_inc pulses, and successive tap_inc pulses are at least SETTLE+WINDOW cycles apart.
- R6: The eye is the widest contiguous run of good taps. When two runs have equal width, the one with the lower taps wins.
- R7: When busy falls, eye_size holds the width of the eye in taps, or 0 if no tap was good.
- R8: On lock, the final tap is lo + floor((width-1)/2), where lo is the lowest tap of the eye. The block reaches it from the top tap using only tap_dec pulses, one per cycle.
- R9: When busy falls, locked is set if the eye width is at least MIN_EYE (default 5) and failed is set otherwise, never both. On failure, tap_value stays at the top tap.
- R10: At most one of tap_inc, tap_dec and tap_load is high in any cycle. tap_value rises by one with tap_inc and falls by one with tap_dec, and is unchanged in cycles with no control pulse.
- R11: A stream whose token runs are shorter than MIN_RUN at every tap, as HDMI blanking with interleaved data produces, ends in failed with eye_size 0.
- R12: After a failure, a new start pulse runs a full new sweep from tap 0 and reports the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin an alignment sweep |
| word | input | 10 | Deserialized channel word |
| tap_inc | output | 1 | Step delay line up one tap |
| tap_dec | output | 1 | Step delay line down one tap |
| tap_load | output | 1 | Load tap_value into the delay line |
| tap_value | output | TAP_W | Tap the delay line holds after the current pulse |
| busy | output | 1 | Sweep or centring in progress |
| locked | output | 1 | Alignment succeeded |
| failed | output | 1 | Alignment failed |
| eye_size | output | TAP_W+1 | Width of the eye in taps |

## Verification
The assertions assume that the delay line follows the control pulses exactly: a load takes tap_value, and each step moves by one tap. They also assume that start is a clean pulse with no constraint on when it arrives. The bench meets this with a behavioural delay line that updates on the same edges as the pulses. It produces words from the bench's own tap, so the settle wait alone absorbs the pipeline delay. The stimulus draws eye positions and widths from a seeded generator, together with directed cases: two eyes of equal width, an eye at the top edge, widths on either side of the minimum, no eye at all, and short HDMI-like token runs. Non-token words are redrawn until they miss the four token codes, so stray runs cannot arise by chance.

// File: rtl/tmds_phase_aligner.sv
module tmds_phase_aligner #(
  parameter int TAP_W    = 5,
  parameter int SETTLE   = 8,
  parameter int WINDOW   = 64,
  parameter int MIN_RUN  = 4,
  parameter int MIN_RUNS = 2,
  parameter int MIN_EYE  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       word,
  output logic             tap_inc,
  output logic             tap_dec,
  output logic             tap_load,
  output logic [TAP_W-1:0] tap_value,
  output logic             busy,
  output logic             locked,
  output logic             failed,
  output logic [TAP_W:0]   eye_size
);
  localparam int CW = $clog2((WINDOW > SETTLE ? WINDOW : SETTLE) + 1);
  localparam int LW = $clog2(MIN_RUN + 1);
  localparam int RW = $clog2(MIN_RUNS + 1);
  localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

  typedef enum logic [2:0] {IDLE, SETTLING, MEASURE, EVAL, FINISH, CENTRE} state_t;
  state_t state;

  logic [CW-1:0]    cnt;
  logic [LW-1:0]    run_len;
  logic [RW-1:0]    runs;
  logic [TAP_W:0]   cur_w, best_w;
  logic [TAP_W-1:0] cur_lo, best_lo, target;

  logic             is_tok, tap_good;
  logic [TAP_W:0]   cur_w_n;
  logic [TAP_W-1:0] cur_lo_n, centre;

  assign is_tok   = (word == 10'b1101010100) || (word == 10'b0010101011) ||
                    (word == 10'b0101010100) || (word == 10'b1010101011);
  assign tap_good = (runs == RW'(MIN_RUNS));
  assign cur_w_n  = cur_w + 1'b1;
  assign cur_lo_n = (cur_w == '0) ? tap_value : cur_lo;
  assign centre   = best_lo + TAP_W'((best_w - 1'b1) >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      run_len   <= '0;
      runs      <= '0;
      cur_w     <= '0;
      best_w    <= '0;
      cur_lo    <= '0;
      best_lo   <= '0;
      target    <= '0;
      tap_inc   <= 1'b0;
      tap_dec   <= 1'b0;
      tap_load  <= 1'b0;
      tap_value <= '0;
      busy      <= 1'b0;
      locked    <= 1'b0;
      failed    <= 1'b0;
      eye_size  <= '0;
    end else begin
      tap_inc  <= 1'b0;
      tap_dec  <= 1'b0;
      tap_load <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          busy      <= 1'b1;
          locked    <= 1'b0;
          failed    <= 1'b0;
          eye_size  <= '0;
          tap_value <= '0;
          tap_load  <= 1'b1;
          cur_w     <= '0;
          best_w    <= '0;
          cnt       <= '0;
          state     <= SETTLING;
        end
        SETTLING: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SETTLE - 1)) begin
            cnt     <= '0;
            run_len <= '0;
            runs    <= '0;
            state   <= MEASURE;
          end
        end
        MEASURE: begin
          if (!is_tok) run_len <= '0;
          else if (run_len != LW'(MIN_RUN)) run_len <= run_len + 1'b1;
          if (is_tok && run_len == LW'(MIN_RUN - 1) && runs != RW'(MIN_RUNS))
            runs <= runs + 1'b1;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WINDOW - 1)) state <= EVAL;
        end
        EVAL: begin
          if (tap_good) begin
            cur_w  <= cur_w_n;
            cur_lo <= cur_lo_n;
            if (cur_w_n > best_w) begin
              best_w  <= cur_w_n;
              best_lo <= cur_lo_n;
            end
          end else begin
            cur_w <= '0;
          end
          if (tap_value == TOP) begin
            state <= FINISH;
          end else begin
            tap_value <= tap_value + 1'b1;
            tap_inc   <= 1'b1;
            cnt       <= '0;
            state     <= SETTLING;
          end
        end
        FINISH: begin
          if (best_w >= (TAP_W+1)'(MIN_EYE)) begin
            target <= centre;
            state  <= CENTRE;
          end else begin
            failed   <= 1'b1;
            busy     <= 1'b0;
            eye_size <= best_w;
            state    <= IDLE;
          end
        end
        CENTRE: begin
          if (tap_value == target) begin
            locked   <= 1'b1;
            busy     <= 1'b0;
            eye_size <= best_w;
            state    <= IDLE;
          end else begin
            tap_value <= tap_value - 1'b1;
            tap_dec   <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmds_phase_aligner_chk.sv
module tmds_phase_aligner_chk #(
  parameter int TAP_W   = 5,
  parameter int MIN_EYE = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tap_inc,
  input logic             tap_dec,
  input logic             tap_load,
  input logic [TAP_W-1:0] tap_value,
  input logic             busy,
  input logic             locked,
  input logic             failed,
  input logic [TAP_W:0]   eye_size
);
  p_ctl_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tap_inc, tap_dec, tap_load}));

  p_inc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_inc |-> tap_value == TAP_W'($past(tap_value) + 1'b1));

  p_dec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_dec |-> tap_value == TAP_W'($past(tap_value) - 1'b1));

  p_hold_tap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_inc || tap_dec || tap_load) |-> $stable(tap_value));

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tap_load && tap_value == '0);

  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && failed) && !(busy && (locked || failed)));

  p_lock_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> eye_size >= (TAP_W+1)'(MIN_EYE));
endmodule

bind tmds_phase_aligner tmds_phase_aligner_chk #(.TAP_W(TAP_W), .MIN_EYE(MIN_EYE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_inc(tap_inc), .tap_dec(tap_dec), .tap_load(tap_load),
  .tap_value(tap_value), .busy(busy), .locked(locked), .failed(failed), .eye_size(eye_size)
);

// File: tb/test_tmds_phase_aligner.sv
`timescale 1ns/1ps
module test_tmds_phase_aligner;
  localparam int TAP_W = 5, SETTLE = 8, WINDOW = 64, MIN_RUN = 4, MIN_RUNS = 2, MIN_EYE = 5;
  localparam int NT = 1 << TAP_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [9:0] word = '0;
  logic tap_inc, tap_dec, tap_load, busy, locked, failed;
  logic [TAP_W-1:0] tap_value;
  logic [TAP_W:0] eye_size;

  always #2 clk = ~clk;

  tmds_phase_aligner #(.TAP_W(TAP_W), .SETTLE(SETTLE), .WINDOW(WINDOW), .MIN_RUN(MIN_RUN),
    .MIN_RUNS(MIN_RUNS), .MIN_EYE(MIN_EYE)) i_tmds_phase_aligner (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word), .tap_inc(tap_inc), .tap_dec(tap_dec),
    .tap_load(tap_load), .tap_value(tap_value), .busy(busy), .locked(locked), .failed(failed),
    .eye_size(eye_size));

  int errors = 0, checks = 0;
  logic [NT-1:0] good_mask = '0;
  int mode = 0;            // 0: DVI runs of 6 tokens, 1: HDMI-like runs of 2
  int dl_tap = 0, phase = 0, cyc = 0;
  int n_load = 0, n_inc = 0, n_dec = 0, short_gaps = 0, last_inc = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tok(input logic [9:0] w);
    return w == 10'b1101010100 || w == 10'b0010101011 || w == 10'b0101010100 || w == 10'b1010101011;
  endfunction

  function automatic logic [9:0] pick_tok(input int r);
    case (r & 3)
      0: return 10'b1101010100;
      1: return 10'b0010101011;
      2: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] non_tok();
    logic [9:0] w = 10'($urandom);
    while (tok(w)) w = 10'($urandom);
    return w;
  endfunction

  // delay line model and pulse monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tap_load) begin dl_tap <= int'(tap_value); n_load <= n_load + 1; last_inc <= -1; end
    if (tap_dec) begin dl_tap <= dl_tap - 1; n_dec <= n_dec + 1; end
    if (tap_inc) begin
      dl_tap <= dl_tap + 1; n_inc <= n_inc + 1; last_inc <= cyc;
      if (last_inc >= 0 && cyc - last_inc < SETTLE + WINDOW) short_gaps <= short_gaps + 1;
    end
  end

  always @(negedge clk) begin
    phase <= (phase + 1) % 16;
    if (good_mask[dl_tap[TAP_W-1:0]] && phase < (mode == 0 ? 6 : 2)) word <= pick_tok($urandom);
    else word <= non_tok();
  end

  function automatic void best_eye(input logic [NT-1:0] m, output int lo, output int w);
    int cl = 0, cw = 0;
    lo = 0; w = 0;
    for (int t = 0; t < NT; t++) begin
      if (m[t]) begin
        if (cw == 0) cl = t;
        cw++;
        if (cw > w) begin w = cw; lo = cl; end
      end else cw = 0;
    end
  endfunction

  task automatic run(input logic [NT-1:0] m, input int md, input bit poke, input string tag);
    int lo, w, l0, i0, d0, g0, exp_tap, wait_c;
    bit exp_lock;
    good_mask = m; mode = md;
    best_eye(m, lo, w);
    if (md == 1) w = 0;
    exp_lock = (w >= MIN_EYE);
    exp_tap = exp_lock ? lo + (w - 1) / 2 : NT - 1;
    l0 = n_load; i0 = n_inc; d0 = n_dec; g0 = short_gaps;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy && tap_load && tap_value == 0 && !locked && !failed && eye_size == 0,
        {"R2 start ", tag}, int'(tap_value), 0);
    if (poke) begin
      repeat (500) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    wait_c = 0;
    while (busy && wait_c < 20000) begin @(negedge clk); wait_c++; end
    chk(!busy, {"R5 sweep ends ", tag}, int'(busy), 0);
    chk(n_inc - i0 == NT - 1, {"R5 inc count ", tag}, n_inc - i0, NT - 1);
    chk(short_gaps == g0, {"R4 settle+window gap ", tag}, short_gaps - g0, 0);
    chk(n_load - l0 == 1, {"R2 single load ", tag}, n_load - l0, 1);
    chk(eye_size == w, {"R6 R7 eye width ", tag}, int'(eye_size), w);
    chk(locked == exp_lock && failed == !exp_lock, {"R9 status ", tag}, int'(locked), int'(exp_lock));
    chk(tap_value == exp_tap && dl_tap == exp_tap, {"R8 final tap ", tag}, int'(tap_value), exp_tap);
    chk(n_dec - d0 == (NT - 1 - exp_tap), {"R8 dec count ", tag}, n_dec - d0, NT - 1 - exp_tap);
  endtask

  function automatic logic [NT-1:0] win(input int lo, input int w);
    logic [NT-1:0] m = '0;
    for (int t = lo; t < lo + w && t < NT; t++) m[t] = 1'b1;
    return m;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!busy && !locked && !failed && eye_size == 0 && tap_value == 0 &&
        !tap_inc && !tap_dec && !tap_load, "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    run(win(10, 9), 0, 0, "R3 R4 dvi eye 10..18");
    run(win(3, 6) | win(20, 6), 0, 0, "R6 tie lower wins");
    run(win(2, 5) | win(14, 8), 0, 0, "R6 wider upper");
    run(win(24, 8), 0, 0, "top edge");
    run(win(7, MIN_EYE), 0, 0, "R9 exactly min");
    run(win(7, MIN_EYE - 1), 0, 0, "R9 below min");
    run('0, 0, 0, "R12 no eye");
    run(win(5, 10), 0, 0, "R12 retry after fail");
    run(win(8, 9), 1, 0, "R11 hdmi short runs");
    run(win(12, 7), 0, 1, "R2 start while busy");
    for (int k = 0; k < 6; k++) begin
      int lo = $urandom_range(0, NT - 1);
      int w = $urandom_range(0, 12);
      logic [NT-1:0] m = win(lo, w);
      if (k % 2 == 1) m = m | win($urandom_range(0, NT - 1), $urandom_range(1, 6));
      run(m, 0, 0, "R6 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule